// File: doc/BRIEF.md
# Memory-Mapped SPI Host Controller

This block is a byte-oriented SPI host that sits behind a 32-bit word register port. Software queues bytes into a 256-deep transmit FIFO. A serial engine sends each byte in SPI mode 0, MSB first, with SCK taken from the system clock through a parameterised divider. Every byte clocked in on MISO is stored in a 256-deep receive FIFO, which software then reads back one byte per word read.

A control bit holds transfers back so that software can queue a batch before starting. Two self-clearing control bits empty either FIFO. A keyed software reset returns the whole block to its reset state. An active-low select register drives the slave-select lines directly. Occupancy registers report how full each FIFO is. Four single-cycle event strobes go to an external interrupt block: transmit FIFO drained, receive data present, receive FIFO filled, and receive overrun.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset, status reads 0x5, control reads 0, SCK is low and every select line is high.
- R2: With control bit 8 clear, a byte written to the transmit data register (0x68) goes out on MOSI MSB first in mode 0: SCK idles low, MOSI is stable while SCK is high, and MISO is sampled on the rising SCK edge. The received byte goes into the receive FIFO and is read from the receive data register (0x6C) in bits 7:0.
- R3: While control bit 8 (at 0x60) is set, no SCK edge occurs and queued bytes stay in the transmit FIFO. Clearing the bit sends them in write order.
- R4: Status at 0x64 has bit 3 for transmit full, bit 2 for transmit empty, bit 1 for receive full and bit 0 for receive empty, with zeros elsewhere. Writes to 0x64 have no effect.
- R5: Writing control with bit 5 set empties the transmit FIFO, and with bit 6 set empties the receive FIFO. Neither bit is stored, so control reads them as 0.
- R6: Writing exactly 0xA to 0x40 restores the reset state of every register and empties both FIFOs. Any other value written there has no effect.
- R7: Reading 0x6C while the receive FIFO is empty returns 0xDEADBEEF and leaves the FIFO empty.
- R8: A byte received while the receive FIFO is full is dropped, and evt_rx_overrun_o pulses for one cycle.
- R9: The select register at 0x70 resets to all ones, reads back as written, and ss_no[i] follows its bit i.
- R10: Transmit occupancy (0x74) and receive occupancy (0x78) read the FIFO fill count minus one, and 0 when the FIFO is empty.
- R11: When a transfer completes and leaves the transmit FIFO empty, evt_tx_empty_o and evt_rx_not_empty_o pulse together for one cycle.
- R12: When a received byte fills the receive FIFO, evt_rx_full_o pulses for one cycle.
- R13: A transmit data write while the transmit FIFO is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops receive data) |
| reg_addr_i | input | 7 | Byte address of a 32-bit register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the cycle of the read strobe |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_no | output | NUM_SS | Slave selects, active low |
| evt_tx_empty_o | output | 1 | Transmit FIFO drained strobe |
| evt_rx_not_empty_o | output | 1 | Receive data present strobe |
| evt_rx_full_o | output | 1 | Receive FIFO filled strobe |
| evt_rx_overrun_o | output | 1 | Receive byte dropped strobe |

## Verification
A corrupt FIFO pointer or count shows up quickly at the ports. The occupancy and status reads go wrong on the next register access, and the bytes read back from the receive FIFO come out of order, up to a full FIFO depth of transfers later. A wrong shift or phase in the engine corrupts every byte the MOSI monitor sees. It also corrupts the inverted loopback value that is read back, so the error is caught in the first byte. Misdecoded control writes show up as SCK edges during inhibit, bytes that survive a flush, or a missing or extra overrun or full strobe when the receive FIFO is filled past its depth.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam logic [6:0] ADR_SRST = 7'h40;
  localparam logic [6:0] ADR_CTRL = 7'h60;
  localparam logic [6:0] ADR_STAT = 7'h64;
  localparam logic [6:0] ADR_TXD  = 7'h68;
  localparam logic [6:0] ADR_RXD  = 7'h6C;
  localparam logic [6:0] ADR_SEL  = 7'h70;
  localparam logic [6:0] ADR_TXOC = 7'h74;
  localparam logic [6:0] ADR_RXOC = 7'h78;

  localparam logic [31:0] SRST_KEY   = 32'h0000_000A;
  localparam logic [31:0] EMPTY_MARK = 32'hDEAD_BEEF;

  localparam int CTRL_TX_FLUSH = 5;
  localparam int CTRL_RX_FLUSH = 6;
  localparam int CTRL_INHIBIT  = 8;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DEPTH = 256,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rp_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else if (flush_i) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + AW'(1);
      if (do_pop)  rp_q <= rp_q + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R10
  AST_FULL_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i && !flush_i |=> full_o && $stable(wp_q)); // R13
  AST_EMPTY_NO_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && pop_i && !push_i && !flush_i |=> empty_o && $stable(rp_q)); // R7
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int CLK_DIV = 2,
  localparam int DW     = $clog2(CLK_DIV + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       abort_i,
  input  logic       start_i,
  input  logic [7:0] tx_byte_i,
  input  logic       miso_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rx_byte_o,
  output logic       sck_o,
  output logic       mosi_o
);
  logic [DW-1:0] div_q;
  logic [2:0]    bit_q;
  logic [7:0]    tx_sr_q, rx_sr_q;
  logic          sck_q, busy_q, done_q, tick;

  assign tick = (div_q == DW'(CLK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0; bit_q <= '0; tx_sr_q <= '0; rx_sr_q <= '0;
      sck_q <= 1'b0; busy_q <= 1'b0; done_q <= 1'b0;
    end else if (abort_i) begin
      div_q <= '0; bit_q <= '0;
      sck_q <= 1'b0; busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          tx_sr_q <= tx_byte_i;
          div_q   <= '0;
          bit_q   <= '0;
          sck_q   <= 1'b0;
        end
      end else if (tick) begin
        div_q <= '0;
        if (!sck_q) begin
          sck_q   <= 1'b1;
          rx_sr_q <= {rx_sr_q[6:0], miso_i};
        end else begin
          sck_q <= 1'b0;
          if (bit_q == 3'd7) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q   <= bit_q + 3'd1;
            tx_sr_q <= {tx_sr_q[6:0], 1'b0};
          end
        end
      end else begin
        div_q <= div_q + DW'(1);
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rx_byte_o = rx_sr_q;
  assign sck_o     = sck_q;
  assign mosi_o    = tx_sr_q[7];

  AST_SCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sck_q); // R2
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_q && $past(sck_q) |-> $stable(mosi_o)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R11
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int FIFO_DEPTH = 256,
  parameter int NUM_SS     = 1,
  parameter int CLK_DIV    = 2,
  localparam int CW        = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [6:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_SS-1:0] ss_no,
  output logic              evt_tx_empty_o,
  output logic              evt_rx_not_empty_o,
  output logic              evt_rx_full_o,
  output logic              evt_rx_overrun_o
);
  logic [31:0]   ctrl_q, sel_q;
  logic          soft_rst, ctrl_wr, inhibit;
  logic          tx_flush, rx_flush, tx_push, tx_pop, rx_push, rx_pop;
  logic [7:0]    tx_head, rx_head, eng_rx;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          eng_busy, eng_done, eng_start;
  logic [31:0]   tx_occ, rx_occ;

  assign soft_rst = reg_wr_i && reg_addr_i == ADR_SRST && reg_wdata_i == SRST_KEY;
  assign ctrl_wr  = reg_wr_i && reg_addr_i == ADR_CTRL;
  assign inhibit  = ctrl_q[CTRL_INHIBIT];
  assign tx_flush = soft_rst || (ctrl_wr && reg_wdata_i[CTRL_TX_FLUSH]);
  assign rx_flush = soft_rst || (ctrl_wr && reg_wdata_i[CTRL_RX_FLUSH]);
  assign tx_push  = reg_wr_i && reg_addr_i == ADR_TXD;
  assign rx_pop   = reg_rd_i && reg_addr_i == ADR_RXD;

  assign eng_start = !eng_busy && !inhibit && !tx_empty && !soft_rst;
  assign tx_pop    = eng_start;
  assign rx_push   = eng_done && !rx_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      sel_q  <= '1;
    end else if (soft_rst) begin
      ctrl_q <= '0;
      sel_q  <= '1;
    end else begin
      if (ctrl_wr) begin
        ctrl_q <= reg_wdata_i;
        ctrl_q[CTRL_TX_FLUSH] <= 1'b0;
        ctrl_q[CTRL_RX_FLUSH] <= 1'b0;
      end
      if (reg_wr_i && reg_addr_i == ADR_SEL) sel_q <= reg_wdata_i;
    end
  end

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_tx_fifo (
    .clk_i, .rst_ni, .flush_i(tx_flush), .push_i(tx_push),
    .wdata_i(reg_wdata_i[7:0]), .pop_i(tx_pop), .rdata_o(tx_head),
    .count_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty));

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rx_fifo (
    .clk_i, .rst_ni, .flush_i(rx_flush), .push_i(rx_push),
    .wdata_i(eng_rx), .pop_i(rx_pop), .rdata_o(rx_head),
    .count_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty));

  spi_shift_engine #(.CLK_DIV(CLK_DIV)) u_engine (
    .clk_i, .rst_ni, .abort_i(soft_rst), .start_i(eng_start),
    .tx_byte_i(tx_head), .miso_i, .busy_o(eng_busy), .done_o(eng_done),
    .rx_byte_o(eng_rx), .sck_o, .mosi_o);

  assign tx_occ = tx_empty ? '0 : 32'(tx_cnt - CW'(1));
  assign rx_occ = rx_empty ? '0 : 32'(rx_cnt - CW'(1));

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADR_CTRL: reg_rdata_o = ctrl_q;
      ADR_STAT: reg_rdata_o = {28'd0, tx_full, tx_empty, rx_full, rx_empty};
      ADR_RXD:  reg_rdata_o = rx_empty ? EMPTY_MARK : {24'd0, rx_head};
      ADR_SEL:  reg_rdata_o = sel_q;
      ADR_TXOC: reg_rdata_o = tx_occ;
      ADR_RXOC: reg_rdata_o = rx_occ;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign ss_no              = sel_q[NUM_SS-1:0];
  assign evt_tx_empty_o     = eng_done && tx_empty;
  assign evt_rx_not_empty_o = eng_done && tx_empty;
  assign evt_rx_full_o      = rx_push && rx_cnt == CW'(FIFO_DEPTH - 1);
  assign evt_rx_overrun_o   = eng_done && rx_full;

  AST_INHIBIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit && !eng_busy && !ctrl_wr |=> !eng_busy); // R3
  AST_OVERRUN_KEEPS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_rx_overrun_o && !rx_pop && !rx_flush |=> rx_full); // R8
  AST_CTRL_FLUSH_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> !ctrl_q[CTRL_TX_FLUSH] && !ctrl_q[CTRL_RX_FLUSH]); // R5
  AST_SRST_SELECTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> &sel_q && ctrl_q == '0 && tx_empty && rx_empty); // R6
endmodule

// File: tb/spi_host_ctrl_bench.sv
`timescale 1ns/1ps
module spi_host_ctrl_bench;
  logic clk_i = 0, rst_ni = 0;
  logic reg_wr_i = 0, reg_rd_i = 0;
  logic [6:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic sck_o, mosi_o, miso_i;
  logic [0:0] ss_no;
  logic evt_tx_empty_o, evt_rx_not_empty_o, evt_rx_full_o, evt_rx_overrun_o;

  int total = 0, bad = 0;
  int drain_cnt = 0, full_cnt = 0, ovr_cnt = 0, sck_rises = 0;
  logic [7:0] mosi_q[$];
  logic [7:0] rx_q[$];

  always #2.5 clk_i = ~clk_i;
  assign miso_i = ~mosi_o;

  spi_host_ctrl u_spi_host_ctrl (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // MOSI monitor: collect 8 bits on rising SCK, compare against driver queue (R2)
  logic [7:0] cur = '0;
  int nb = 0;
  always @(posedge sck_o) begin
    sck_rises++;
    cur = {cur[6:0], mosi_o};
    nb++;
    if (nb == 8) begin
      nb = 0;
      if (mosi_q.size() == 0) chk("R2 mosi unexpected byte", {24'd0, cur}, 32'hxx);
      else chk("R2 mosi byte", {24'd0, cur}, {24'd0, mosi_q.pop_front()});
    end
  end

  always @(negedge clk_i) begin
    if (evt_tx_empty_o) begin
      drain_cnt++;
      chk("R11 paired strobe", {31'd0, evt_rx_not_empty_o}, 32'd1);
    end
    if (evt_rx_full_o) full_cnt++;
    if (evt_rx_overrun_o) ovr_cnt++;
  end

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_rd_i = 1; reg_addr_i = a;
    #1 d = reg_rdata_o;
    @(negedge clk_i);
    reg_rd_i = 0;
  endtask

  task automatic send(input logic [7:0] b, input bit keep_rx);
    mosi_q.push_back(b);
    if (keep_rx) rx_q.push_back(~b);
    wr(7'h68, {24'd0, b});
  endtask

  task automatic wait_drain();
    int s = drain_cnt;
    while (drain_cnt == s) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic rd_expect(input string req);
    logic [31:0] d;
    rd(7'h6C, d);
    chk(req, d, {24'd0, rx_q.pop_front()});
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int s;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // reset state
    rd(7'h64, d); chk("R1 status", d, 32'h5);
    rd(7'h60, d); chk("R1 ctrl", d, 32'h0);
    chk("R1 sck", {31'd0, sck_o}, 32'd0);
    chk("R9 ss reset", {31'd0, ss_no}, 32'd1);
    rd(7'h70, d); chk("R9 sel reg", d, 32'hFFFF_FFFF);
    rd(7'h74, d); chk("R10 tx occ empty", d, 0);
    rd(7'h78, d); chk("R10 rx occ empty", d, 0);

    // single byte
    send(8'hA5, 1);
    wait_drain();
    rd(7'h78, d); chk("R10 rx occ one", d, 0);
    rd(7'h64, d); chk("R4 status rx data", d, 32'h4);
    rd_expect("R2 rx byte");
    rd(7'h6C, d); chk("R7 empty marker", d, 32'hDEAD_BEEF);
    rd(7'h64, d); chk("R7 still empty", d, 32'h5);

    // inhibit
    wr(7'h60, 32'h100);
    s = sck_rises;
    send(8'h3C, 1); send(8'hC3, 1); send(8'h81, 1);
    repeat (200) @(negedge clk_i);
    chk("R3 no sck while inhibited", sck_rises, s);
    rd(7'h74, d); chk("R10 tx occ three", d, 2);
    rd(7'h60, d); chk("R3 ctrl readback", d, 32'h100);
    wr(7'h64, 32'hF);
    rd(7'h64, d); chk("R4 status write ignored", d, 32'h1);
    wr(7'h60, 32'h0);
    wait_drain();
    rd(7'h78, d); chk("R10 rx occ three", d, 2);
    for (int i = 0; i < 3; i++) rd_expect("R3 order");

    // flush bits
    wr(7'h60, 32'h100);
    wr(7'h68, 32'h55); wr(7'h68, 32'h66);
    wr(7'h60, 32'h120);
    rd(7'h60, d); chk("R5 flush bit not stored", d, 32'h100);
    rd(7'h64, d); chk("R5 tx flushed", d, 32'h5);
    s = sck_rises;
    wr(7'h60, 32'h0);
    repeat (100) @(negedge clk_i);
    chk("R5 nothing sent after flush", sck_rises, s);
    send(8'h42, 1);
    wait_drain();
    wr(7'h60, 32'h40);
    rx_q.delete();
    rd(7'h64, d); chk("R5 rx flushed", d, 32'h5);
    rd(7'h60, d); chk("R5 ctrl after rx flush", d, 32'h0);
    rd(7'h6C, d); chk("R7 marker after flush", d, 32'hDEAD_BEEF);

    // slave select
    wr(7'h70, 32'h0);
    chk("R9 ss follows", {31'd0, ss_no}, 32'd0);
    rd(7'h70, d); chk("R9 sel readback", d, 32'h0);

    // soft reset
    wr(7'h60, 32'h100);
    wr(7'h68, 32'h99);
    wr(7'h40, 32'h5);
    chk("R6 bad key ss", {31'd0, ss_no}, 32'd0);
    rd(7'h60, d); chk("R6 bad key ctrl", d, 32'h100);
    rd(7'h74, d); chk("R6 bad key tx occ", d, 0);
    rd(7'h64, d); chk("R6 bad key status", d, 32'h1);
    wr(7'h40, 32'hA);
    chk("R6 ss restored", {31'd0, ss_no}, 32'd1);
    rd(7'h60, d); chk("R6 ctrl cleared", d, 32'h0);
    rd(7'h64, d); chk("R6 status reset", d, 32'h5);

    // fill both FIFOs
    wr(7'h60, 32'h100);
    for (int i = 0; i < 256; i++) send(8'(i * 7 + 3), 1);
    rd(7'h64, d); chk("R4 tx full", d, 32'h9);
    rd(7'h74, d); chk("R10 tx occ full", d, 255);
    wr(7'h68, 32'h77);
    rd(7'h74, d); chk("R13 write when full dropped", d, 255);
    wr(7'h60, 32'h0);
    wait_drain();
    chk("R12 rx full strobe", full_cnt, 1);
    rd(7'h64, d); chk("R4 rx full", d, 32'h6);
    rd(7'h78, d); chk("R10 rx occ full", d, 255);
    send(8'h11, 0);
    wait_drain();
    chk("R8 overrun strobe", ovr_cnt, 1);
    chk("R12 no second full strobe", full_cnt, 1);
    rd(7'h78, d); chk("R8 rx occ unchanged", d, 255);
    for (int i = 0; i < 256; i++) rd_expect("R8 kept bytes");
    rd(7'h6C, d); chk("R7 marker after drain", d, 32'hDEAD_BEEF);
    chk("R2 all bytes seen", mosi_q.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule